// File: doc/BRIEF.md
# Rate-Controlled Stream Test Pattern Generator

This block stands in for an image sensor on a stream-style sensor interface. It produces synthetic beats on a valid/ready/last stream so that the packetizing and transmit logic downstream can be brought up and checked without any real sensor attached. Software configures it through a small word-write register port. The port sets a control word (run enable and repeat selection), a pattern mode, a beat rate and a frame length.

The beat rate is a 16-bit fraction of the clock. A phase accumulator adds the rate value every cycle, and each carry out of the accumulator offers one beat. In counting mode, each beat carries the number of beats accepted since the run was started. The last beat of every frame is flagged. A run is either a single frame, after which the enable bit clears itself, or a repeating sequence of frames that goes on until software clears the enable bit. Clearing the enable bit never cuts a frame short: the frame in flight is finished first.

Top module: `tpg_stream`

## Requirements
- R1: After reset the generator is disabled and `m_tvalid` and `m_tlast` are low.
- R2: Writes with `wr_en` high go to the register at `wr_addr`: 0 control (bit 0 run enable, bit 1 repeat mode), 1 pattern mode, 2 rate R (low 16 bits), 3 frame length L (low 16 bits).
- R3: While running with `m_tready` held high, beats are accepted on R/65536 of the cycles on average (one beat per carry of a 16-bit accumulator that starts at zero at run start). A rate of 0 produces no beats.
- R4: Once `m_tvalid` is high it stays high, with `m_tdata` and `m_tlast` unchanged, until a cycle in which `m_tready` is high.
- R5: In pattern mode 1, `m_tdata` equals the number of beats accepted since the run started, beginning at 0. In any other mode `m_tdata` is 0.
- R6: `m_tlast` is high on beat index L-1 of each frame of L beats, and only while `m_tvalid` is high. An L of 0 means 65536 beats.
- R7: With repeat mode clear, exactly one frame is produced, then the enable bit clears itself and no further beats appear.
- R8: With repeat mode set, frames follow one another and the count continues across frame boundaries.
- R9: Clearing the enable bit in the middle of a frame lets that frame finish, and no new frame is begun afterwards.
- R10: Setting the enable bit while the generator is stopped and no frame is in flight restarts the count and the accumulator from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register index |
| wr_data | input | 32 | Register write data |
| m_tdata | output | 32 | Stream payload |
| m_tvalid | output | 1 | Beat offered |
| m_tready | input | 1 | Downstream accepts the beat |
| m_tlast | output | 1 | Final beat of a frame |

## Verification
The hardest situation to reach from the ports is a disable that arrives in the middle of a frame while the downstream side is stalling, with a beat possibly already held and waiting. The bench runs repeating frames at full rate under a periodic ready pattern. It waits until the accepted-beat count is part way into a frame, then clears the enable bit. It then confirms that the total number of accepted beats is a whole number of frames and that every beat matched the queued count and last-flag values. Rate accuracy is measured separately by counting accepted beats over a fixed window at a quarter rate.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_MODE = 2'd1,
    REG_RATE = 2'd2,
    REG_FLEN = 2'd3
  } reg_addr_e;

  localparam int MODE_W = 8;
  localparam logic [MODE_W-1:0] MODE_COUNT = 8'd1;
endpackage

// File: rtl/tpg_regs.sv
module tpg_regs
  import tpg_pkg::*;
#(
  parameter int REG_W  = 32,
  parameter int RATE_W = 16,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              frame_end,
  input  logic              idle,
  output logic              en_q,
  output logic              en_nxt,
  output logic              cont_q,
  output logic [MODE_W-1:0] mode_q,
  output logic [RATE_W-1:0] rate_q,
  output logic [LEN_W-1:0]  flen_q,
  output logic              start
);
  logic              cont_nxt;
  logic [MODE_W-1:0] mode_nxt;
  logic [RATE_W-1:0] rate_nxt;
  logic [LEN_W-1:0]  flen_nxt;

  always_comb begin
    en_nxt   = en_q;
    cont_nxt = cont_q;
    mode_nxt = mode_q;
    rate_nxt = rate_q;
    flen_nxt = flen_q;
    start    = 1'b0;
    // single-frame run: enable drops once the last beat is taken
    if (frame_end && !cont_q) en_nxt = 1'b0;
    if (wr_en) begin
      unique case (reg_addr_e'(wr_addr))
        REG_CTRL: begin
          en_nxt   = wr_data[0];
          cont_nxt = wr_data[1];
          start    = wr_data[0] && !en_q && idle;
        end
        REG_MODE: mode_nxt = wr_data[MODE_W-1:0];
        REG_RATE: rate_nxt = wr_data[RATE_W-1:0];
        REG_FLEN: flen_nxt = wr_data[LEN_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      cont_q <= 1'b0;
      mode_q <= '0;
      rate_q <= '0;
      flen_q <= '0;
    end else begin
      en_q   <= en_nxt;
      cont_q <= cont_nxt;
      mode_q <= mode_nxt;
      rate_q <= rate_nxt;
      flen_q <= flen_nxt;
    end
  end
endmodule

// File: rtl/tpg_rate.sv
module tpg_rate #(
  parameter int RATE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              run,
  input  logic [RATE_W-1:0] rate,
  output logic              tick
);
  logic [RATE_W-1:0] acc_q, acc_nxt, sum;
  logic              carry;
  logic              acc_ce;

  assign {carry, sum} = {1'b0, acc_q} + {1'b0, rate};
  assign tick   = run && carry && !clear;
  assign acc_ce = clear || run;

  always_comb begin
    acc_nxt = acc_q;
    if (clear)    acc_nxt = '0;
    else if (run) acc_nxt = sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_ce) acc_q <= acc_nxt;
  end
endmodule

// File: rtl/tpg_framer.sv
module tpg_framer
  import tpg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              tick,
  input  logic              en_nxt,
  input  logic [MODE_W-1:0] mode,
  input  logic [LEN_W-1:0]  flen,
  input  logic              tready,
  output logic              tvalid,
  output logic [DATA_W-1:0] tdata,
  output logic              tlast,
  output logic              frame_end,
  output logic              idle
);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  logic              pend_q, pend_nxt;
  logic [LEN_W-1:0]  beat_q, beat_nxt, beat_after;
  logic [DATA_W-1:0] cnt_q, cnt_nxt;
  logic              accept, last_beat, gen_ok;

  assign accept    = pend_q && tready;
  assign last_beat = (beat_q == flen - ONE);
  assign frame_end = accept && last_beat;
  assign idle      = !pend_q && (beat_q == '0);

  always_comb begin
    beat_after = beat_q;
    if (accept) beat_after = last_beat ? '0 : beat_q + ONE;
    // a new beat may start only inside a frame or while still enabled
    gen_ok   = en_nxt || (beat_after != '0);
    pend_nxt = (pend_q && !tready) || (tick && gen_ok);
    beat_nxt = start ? '0 : beat_after;
    cnt_nxt  = cnt_q;
    if (start)       cnt_nxt = '0;
    else if (accept) cnt_nxt = cnt_q + DATA_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      beat_q <= '0;
      cnt_q  <= '0;
    end else begin
      pend_q <= pend_nxt;
      beat_q <= beat_nxt;
      cnt_q  <= cnt_nxt;
    end
  end

  assign tvalid = pend_q;
  assign tlast  = pend_q && last_beat;
  assign tdata  = (mode == MODE_COUNT) ? cnt_q : '0;
endmodule

// File: rtl/tpg_stream.sv
module tpg_stream
  import tpg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_W  = 32,
  parameter int RATE_W = 16,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [REG_W-1:0]  wr_data,
  output logic [DATA_W-1:0] m_tdata,
  output logic              m_tvalid,
  input  logic              m_tready,
  output logic              m_tlast
);
  logic              en_q, en_nxt, cont_q, start, tick, frame_end, idle;
  logic [MODE_W-1:0] mode_q;
  logic [RATE_W-1:0] rate_q;
  logic [LEN_W-1:0]  flen_q;

  tpg_regs #(.REG_W(REG_W), .RATE_W(RATE_W), .LEN_W(LEN_W)) u_regs (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data,
    .frame_end, .idle, .en_q, .en_nxt, .cont_q,
    .mode_q, .rate_q, .flen_q, .start
  );

  tpg_rate #(.RATE_W(RATE_W)) u_rate (
    .clk, .rst_n, .clear(start), .run(en_q || !idle),
    .rate(rate_q), .tick
  );

  tpg_framer #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_framer (
    .clk, .rst_n, .start, .tick, .en_nxt, .mode(mode_q), .flen(flen_q),
    .tready(m_tready), .tvalid(m_tvalid), .tdata(m_tdata), .tlast(m_tlast),
    .frame_end, .idle
  );
endmodule

// File: rtl/tpg_stream_chk.sv
module tpg_stream_chk #(
  parameter int DATA_W = 32,
  parameter int RATE_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              m_tvalid,
  input logic              m_tready,
  input logic              m_tlast,
  input logic [DATA_W-1:0] m_tdata,
  input logic              en_q,
  input logic              cont_q,
  input logic              idle,
  input logic [RATE_W-1:0] rate_q
);
  // R4: a waiting beat keeps its payload
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast)));

  // R6: last flag only accompanies a valid beat
  assert_last_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    m_tlast |-> m_tvalid);

  // R7: single-frame run drops enable after its final beat
  assert_selfclear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && m_tready && m_tlast && !cont_q && !wr_en) |=> !en_q);

  // R9: stopped and between frames means no new beat
  assert_stop_at_boundary_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && idle && !wr_en) |=> !m_tvalid);

  // R3: zero rate never offers a beat
  assert_rate_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_q == '0 && !m_tvalid) |=> !m_tvalid);
endmodule

bind tpg_stream tpg_stream_chk #(.DATA_W(DATA_W), .RATE_W(RATE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .m_tvalid(m_tvalid),
  .m_tready(m_tready), .m_tlast(m_tlast), .m_tdata(m_tdata),
  .en_q(en_q), .cont_q(cont_q), .idle(idle), .rate_q(rate_q)
);

// File: tb/tpg_stream_tb.sv
`timescale 1ns/1ps
module tpg_stream_tb;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en;
  logic [1:0]    wr_addr;
  logic [31:0]   wr_data;
  logic [DW-1:0] m_tdata;
  logic          m_tvalid, m_tready, m_tlast;

  int checks = 0;
  int errors = 0;
  int accepted = 0;
  bit mon_on = 1'b0;
  bit done = 1'b0;
  logic [DW:0] exp_q[$];

  always #5 clk = ~clk;

  tpg_stream u_dut (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data,
    .m_tdata, .m_tvalid, .m_tready, .m_tlast
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic write_reg(input logic [1:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  // driver side: queue expected {last, data} items
  task automatic push_frames(input int nbeats, input int flen, input bit count_mode);
    for (int i = 0; i < nbeats; i++)
      exp_q.push_back({(i % flen) == flen - 1, count_mode ? DW'(i) : DW'(0)});
  endtask

  // monitor: compares accepted beats and holding behaviour
  logic          prev_v, prev_r, prev_l;
  logic [DW-1:0] prev_d;
  always @(negedge clk) begin
    if (mon_on) begin
      if (prev_v && !prev_r) begin
        check(m_tvalid && m_tdata == prev_d && m_tlast == prev_l, "R4",
              "held beat changed", m_tdata, prev_d);
      end
      if (m_tvalid && m_tready) begin
        accepted++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R7", "unexpected beat", m_tdata, -1);
        end else begin
          logic [DW:0] e;
          e = exp_q.pop_front();
          check(m_tdata == e[DW-1:0], "R5", "beat data", m_tdata, e[DW-1:0]);
          check(m_tlast == e[DW], "R6", "beat last", m_tlast, e[DW]);
        end
      end
    end
    prev_v = m_tvalid; prev_r = m_tready; prev_l = m_tlast; prev_d = m_tdata;
  end

  // ready pattern: 0 always ready, 1 periodic stalls
  int bp_mode = 0;
  int cyc = 0;
  always @(posedge clk) begin
    #1;
    cyc++;
    m_tready = (bp_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; m_tready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!m_tvalid && !m_tlast, "R1", "reset outputs", m_tvalid, 0);
    @(posedge clk); #1 rst_n = 1'b1;
    mon_on = 1'b1;

    // R2 R5 R6 R7: single frame in count mode
    write_reg(2'd1, 32'd1);
    write_reg(2'd2, 32'h8000);
    write_reg(2'd3, 32'd5);
    push_frames(5, 5, 1'b1);
    accepted = 0;
    write_reg(2'd0, 32'h1);
    repeat (100) @(negedge clk);
    check(exp_q.size() == 0, "R7", "single frame beats left", exp_q.size(), 0);
    check(accepted == 5, "R7", "single frame beat count", accepted, 5);
    repeat (100) @(negedge clk);
    check(accepted == 5 && !m_tvalid, "R7", "no beats after single frame", accepted, 5);

    // R10: re-enable restarts the count
    push_frames(5, 5, 1'b1);
    accepted = 0;
    write_reg(2'd0, 32'h1);
    repeat (100) @(negedge clk);
    check(accepted == 5 && exp_q.size() == 0, "R10", "restart count", accepted, 5);

    // R5: non-count mode gives zero payload
    write_reg(2'd1, 32'd0);
    write_reg(2'd3, 32'd3);
    push_frames(3, 3, 1'b0);
    accepted = 0;
    write_reg(2'd0, 32'h1);
    repeat (100) @(negedge clk);
    check(accepted == 3 && exp_q.size() == 0, "R5", "zero mode frame", accepted, 3);

    // R8 R9 R4: repeating frames, stalls, disable mid-frame
    write_reg(2'd1, 32'd1);
    write_reg(2'd2, 32'hFFFF);
    write_reg(2'd3, 32'd8);
    bp_mode = 1;
    push_frames(400, 8, 1'b1);
    accepted = 0;
    write_reg(2'd0, 32'h3);
    while (accepted < 30) @(negedge clk);
    write_reg(2'd0, 32'h0);
    repeat (200) @(negedge clk);
    check(accepted >= 32, "R8", "frames repeated", accepted, 32);
    check((accepted % 8) == 0, "R9", "whole frames after disable", accepted % 8, 0);
    check(!m_tvalid, "R9", "idle after disable", m_tvalid, 0);
    exp_q.delete();
    bp_mode = 0;

    // R3: quarter rate measured over a window
    write_reg(2'd2, 32'h4000);
    push_frames(1000, 8, 1'b1);
    accepted = 0;
    write_reg(2'd0, 32'h3);
    repeat (800) @(negedge clk);
    check(accepted >= 198 && accepted <= 201, "R3", "quarter rate beats", accepted, 200);
    write_reg(2'd0, 32'h0);
    repeat (100) @(negedge clk);
    check((accepted % 8) == 0, "R9", "whole frames at quarter rate", accepted % 8, 0);
    exp_q.delete();

    // R3: zero rate gives no beats
    write_reg(2'd2, 32'h0);
    accepted = 0;
    write_reg(2'd0, 32'h3);
    repeat (300) @(negedge clk);
    check(accepted == 0 && !m_tvalid, "R3", "zero rate", accepted, 0);
    write_reg(2'd0, 32'h0);
    repeat (10) @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule